// File: doc/BRIEF.md
# Two-Phase Execute Strobe Generator

This block gives a processor that finishes one instruction per cycle its per-instruction timing. A slow main phase arrives from the clock selector. The block samples that phase on a fast master clock and re-issues it as phase 0. It also makes phase 1, which is phase 0 delayed by a selectable number of master cycles. That delay is chosen to cover the time an instruction takes to decode. A tapped shift register produces the delay and plays the part that a chain of transparent latches would play in discrete logic.

Two strobes come from phase 0 and phase 1 through plain gating. The count strobe is high while both phases are high, so it opens once decode has settled. The store strobe opens when phase 0 falls and stays high until phase 1 falls. The instruction is fetched on the rise of phase 0, the data register counts on the rise of phase 1, and memory is written from the fall of phase 0. For these three events to stay in order, each half of the main phase must last longer than the delay, so the whole period must be longer than twice the delay.

The block has no data stream. Every pin is a plain control level, so the block has no valid/ready handshake and no back-pressure.

Top module: `two_phase_strobe_gen`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0, the delay chain is cleared and the latched delay is 1.
- R2: `ph0_o` equals the value `phase_in` had at the previous master clock edge, a latency of one cycle.
- R3: `ph1_o` equals `ph0_o` delayed by D master cycles. D is the latched delay. A setting of 0 is taken as 1, and any setting above `MAX_TAPS` is taken as `MAX_TAPS`.
- R4: The delay is latched only on the edge where `ph0_o` rises. A change of `delay_sel` at any other time leaves `ph1_o` unchanged until the next rise of `ph0_o`.
- R5: `add_clk_o` is high exactly when `ph0_o` and `ph1_o` are both high. It therefore rises D cycles after `ph0_o` rises and falls in the same cycle that `ph0_o` falls.
- R6: `wr_clk_o` is high exactly when `ph1_o` is high and `ph0_o` is low. It rises in the cycle where `add_clk_o` falls and lasts D cycles.
- R7: `add_clk_o` and `wr_clk_o` are never high in the same cycle. When `ph0_o` rises, `ph1_o` is already low, so the write has finished before the next fetch.
- R8: The timing rule is that every high run and every low run of the phase input lasts more than D master cycles. An assertion reports any input that breaks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phase_in | input | 1 | Main phase from the clock selector |
| delay_sel | input | DLY_W | Requested decode delay, in master cycles |
| ph0_o | output | 1 | Phase 0: the main phase, re-timed |
| ph1_o | output | 1 | Phase 1: phase 0 delayed by D cycles |
| add_clk_o | output | 1 | Count strobe for the data register |
| wr_clk_o | output | 1 | Store strobe for the memory write |

## Verification
The end of the count strobe and the start of the store strobe fall on the same master edge, which is the fall of phase 0. A bug that shifted either strobe by one cycle would make them overlap or leave a gap between them. The sweep provokes this boundary with half-periods only one to three cycles longer than every legal delay, and with settings outside the legal range. In every cycle the bench compares both strobes with values it derives itself, and it checks that the two strobes are never high together. A second hazard is a delay change that arrives while phase 0 is high. The bench makes that change and checks that the fall of phase 1 still uses the old delay.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef struct packed {
    logic lead;
    logic lag;
  } phase_pair_t;

  typedef struct packed {
    logic count;
    logic store;
  } strobe_pair_t;
endpackage

// File: rtl/tps_delay_line.sv
module tps_delay_line #(
  parameter int MAX_TAPS = 12,
  parameter int DLY_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lead_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] sel_i,
  output logic [DLY_W-1:0] taps_o,
  output logic             lag_o
);
  logic [MAX_TAPS-1:0] chain;
  logic [DLY_W-1:0]    sel_clamped;
  logic [DLY_W-1:0]    taps_q;

  generate
    for (genvar i = 0; i < MAX_TAPS; i++) begin : gen_stage
      if (i == 0) begin : gen_head
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= lead_i;
      end else begin : gen_body
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_comb begin
    if (sel_i == '0)                         sel_clamped = DLY_W'(1);
    else if (int'(sel_i) > MAX_TAPS)         sel_clamped = DLY_W'(MAX_TAPS);
    else                                     sel_clamped = sel_i;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      taps_q <= DLY_W'(1);
    else if (load_i) taps_q <= sel_clamped;

  always_comb begin
    lag_o = 1'b0;
    for (int k = 0; k < MAX_TAPS; k++)
      if (taps_q == DLY_W'(k + 1)) lag_o = chain[k];
  end

  assign taps_o = taps_q;

  AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(taps_q)); // R4
endmodule

// File: rtl/tps_combiner.sv
module tps_combiner
  import tps_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  phase_pair_t  ph_i,
  output strobe_pair_t st_o
);
  always_comb begin
    st_o.count = ph_i.lead & ph_i.lag;
    st_o.store = ~ph_i.lead & ph_i.lag;
  end

  AST_WR_AFTER_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_o.store) |-> $fell(st_o.count)); // R6
  AST_LAG_LOW_AT_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_i.lead) |-> !ph_i.lag); // R7
endmodule

// File: rtl/tps_half_monitor.sv
module tps_half_monitor #(
  parameter int MAX_TAPS = 12,
  parameter int DLY_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_i,
  input  logic             lead_i,
  input  logic [DLY_W-1:0] taps_i
);
  localparam int RUN_W = DLY_W + 1;
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MAX_TAPS + 1);

  logic             toggle;
  logic             armed;
  logic [RUN_W-1:0] run_len;

  assign toggle = phase_i ^ lead_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      armed   <= 1'b0;
    end else if (toggle) begin
      run_len <= RUN_W'(1);
      armed   <= 1'b1;
    end else if (run_len != RUN_SAT) begin
      run_len <= run_len + RUN_W'(1);
    end
  end

  AST_HALF_EXCEEDS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && armed) |-> (run_len > {1'b0, taps_i})); // R8
endmodule

// File: rtl/two_phase_strobe_gen.sv
module two_phase_strobe_gen
  import tps_pkg::*;
#(
  parameter int MAX_TAPS = 12,
  parameter int DLY_W    = $clog2(MAX_TAPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_in,
  input  logic [DLY_W-1:0] delay_sel,
  output logic             ph0_o,
  output logic             ph1_o,
  output logic             add_clk_o,
  output logic             wr_clk_o
);
  logic             ph0_q;
  logic             warm;
  logic             load;
  logic             lag;
  logic [DLY_W-1:0] taps;
  phase_pair_t      phases;
  strobe_pair_t     strobes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph0_q <= 1'b0;
      warm  <= 1'b0;
    end else begin
      ph0_q <= phase_in;
      warm  <= 1'b1;
    end
  end

  assign load = phase_in & ~ph0_q;

  tps_delay_line #(.MAX_TAPS(MAX_TAPS), .DLY_W(DLY_W)) u_line (
    .clk(clk), .rst_n(rst_n), .lead_i(ph0_q), .load_i(load),
    .sel_i(delay_sel), .taps_o(taps), .lag_o(lag)
  );

  assign phases.lead = ph0_q;
  assign phases.lag  = lag;

  tps_combiner u_comb (
    .clk(clk), .rst_n(rst_n), .ph_i(phases), .st_o(strobes)
  );

  tps_half_monitor #(.MAX_TAPS(MAX_TAPS), .DLY_W(DLY_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .phase_i(phase_in), .lead_i(ph0_q), .taps_i(taps)
  );

  assign ph0_o     = ph0_q;
  assign ph1_o     = lag;
  assign add_clk_o = strobes.count;
  assign wr_clk_o  = strobes.store;

  AST_PH0_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |=> (ph0_o == $past(phase_in))); // R2
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ph1_o) |-> !ph0_o); // R6
endmodule

// File: tb/sim_two_phase_strobe_gen.sv
module sim_two_phase_strobe_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MAXT = 12;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_in = 1'b0;
  logic [DW-1:0] delay_sel = '0;
  logic ph0_o, ph1_o, add_clk_o, wr_clk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_hist = '0;
  logic        m_ph0 = 1'b0;
  int          m_d = 1;
  int          run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_phase_strobe_gen #(.MAX_TAPS(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .delay_sel(delay_sel),
    .ph0_o(ph0_o), .ph1_o(ph1_o), .add_clk_o(add_clk_o), .wr_clk_o(wr_clk_o)
  );

  function automatic int clampd(input int s);
    if (s == 0) return 1;
    if (s > MAXT) return MAXT;
    return s;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic pin, input int dsel);
    logic e1;
    phase_in  = pin;
    delay_sel = DW'(dsel);
    @(posedge clk);
    if (pin && !m_ph0) m_d = clampd(dsel);
    if (pin != m_ph0) begin
      if (run > 0) begin
        n_chk++;
        if (!(run > m_d)) begin
          n_bad++;
          $display("FAIL R8 actual=%0d expected>%0d", run, m_d);
        end
      end
      run = 1;
    end else if (run > 0) run++;
    m_hist = {m_hist[14:0], m_ph0};
    m_ph0  = pin;
    @(negedge clk);
    e1 = m_hist[m_d-1];
    chk("R2", ph0_o, m_ph0);
    chk("R3", ph1_o, e1);
    chk("R5", add_clk_o, m_ph0 & e1);
    chk("R6", wr_clk_o, ~m_ph0 & e1);
    chk("R7", add_clk_o & wr_clk_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", ph0_o, 1'b0);
    chk("R1", ph1_o, 1'b0);
    chk("R1", add_clk_o, 1'b0);
    chk("R1", wr_clk_o, 1'b0);
    rst_n = 1'b1;
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 14; c++) step(1'b0, s);
      for (int h = 1; h <= 3; h++)
        for (int l = 1; l <= 3; l++) begin
          for (int c = 0; c < clampd(s) + h; c++) step(1'b1, s);
          for (int c = 0; c < clampd(s) + l; c++) step(1'b0, s);
        end
    end
    // R4: setting changed while phase 0 is high applies only at the next rise
    for (int c = 0; c < 14; c++) step(1'b0, 5);
    for (int c = 0; c < 7; c++)  step(1'b1, 5);
    for (int c = 0; c < 7; c++)  step(1'b1, 9);
    for (int c = 0; c < 14; c++) step(1'b0, 9);
    for (int c = 0; c < 14; c++) step(1'b1, 2);
    for (int c = 0; c < 14; c++) step(1'b0, 2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule